// File: doc/BRIEF.md
# Fracturable 4-input LUT cell with ripple carry

The block is a row of configurable logic cells, each built around a 4-input lookup table held in 16 configuration bits. Every cell drives two things at once. The first is a full 4-input function on its main output. The second is a pair of 2-input sub-functions tapped from inside the LUT's selection tree. These two internal taps act as a propagate term and a generate term. A 2:1 carry multiplexer uses them to form the cell's carry output from its carry input. The same 16-bit table therefore serves either as a general function or as one stage of a ripple-carry adder.

The third LUT input of each cell comes from one of two sources, picked by a seventeenth configuration bit: the general input line or the carry input. With the carry input selected, one cell computes a sum bit on its main output and a carry on its carry output. Cells are chained so that each carry output feeds the next cell's carry input. The chain's first carry input is a port of the block.

All configuration bits across the chain form a single serial shift register. It is loaded one bit per clock while a shift enable is high, and its top bit is brought out so that several such rows can be daisy-chained. While the shift enable is low, the configuration holds. The cell outputs are then purely combinational functions of the data inputs.

Top module: `flc_chain`

## Requirements
- R1: A synchronous active-high reset clears every configuration bit, so that after reset every main output, every carry output and the serial output are 0.
- R2: Each cell's main output equals table bit T[idx], where idx = {in3, in2, in1, in0} with in0 the least significant bit. LUT inputs 0, 1 and 3 come from the cell's general inputs 0, 1 and 3.
- R3: LUT input 2 is taken from general input 2 when the cell's selector bit is 0, and from the cell's carry input when it is 1.
- R4: The propagate term of a cell is T[8 + {in1, in0}] and its generate term is T[12 + {in1, in0}]. Neither depends on LUT inputs 2 or 3.
- R5: The carry output equals the carry input when the propagate term is 1, and equals the generate term when the propagate term is 0.
- R6: The carry input of cell 0 is the `ci` port, and the carry input of cell k>0 is the carry output of cell k-1.
- R7: On each clock edge with `cfg_shift_en` high, the configuration register shifts one place toward its higher index and `cfg_sin` enters bit 0. Cell k uses bits [17k+15:17k] as its table T and bit 17k+16 as its selector.
- R8: While `cfg_shift_en` is low, `cfg_sin` has no effect. With stable data inputs, every output holds its value.
- R9: `cfg_sout` always shows the highest configuration bit (bit 17*NCELL-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst | input | 1 | Synchronous active-high reset of the configuration |
| cfg_shift_en | input | 1 | Shift one configuration bit in per cycle when high |
| cfg_sin | input | 1 | Serial configuration data in |
| cfg_sout | output | 1 | Highest configuration bit, for daisy-chaining |
| li | input | NCELL*K | General inputs, cell k on bits [kK+K-1:kK] |
| ci | input | 1 | Carry input of cell 0 |
| o | output | NCELL | Main 4-input function output of each cell |
| co | output | NCELL | Carry output of each cell |

## Verification
The bench sweeps every table index on cells that hold different tables. A swapped input order or a wrong table slice in the selection tree then shows up as wrong main outputs. A chain of cells set up for propagate, generate and kill receives every carry-in and operand pattern, so a carry multiplexer with its legs swapped breaks the ripple, and so does a propagate tap taken from the wrong tree node. A full 4-bit add sweep with the carry feeding LUT input 2 exposes a selector that ignores the carry or picks the wrong source. Holding the data inputs while toggling the serial input with the shift idle catches configuration that leaks in without enable. Configurations are chosen so that the top bit differs between loads, so a serial output drawn from the wrong end of the register is caught.

// File: rtl/flc_pkg.sv
package flc_pkg;

  // LUT input that can be replaced by the carry input
  localparam int unsigned FLC_CI_INPUT = 2;

  // Heap index of a fractured tap node (which=0 propagate, 1 generate)
  function automatic int unsigned flc_tap_node(input int unsigned k, input int unsigned which);
    return (32'd1 << (k - 1)) - 2 + which;
  endfunction

  // First table bit covered by a fractured tap node
  function automatic int unsigned flc_tap_leaf(input int unsigned k, input int unsigned which);
    return (32'd1 << k) - 8 + 4 * which;
  endfunction

endpackage

// File: rtl/flc_cfg_shift.sv
module flc_cfg_shift #(
  parameter int unsigned W = 68
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         sin,
  output logic [W-1:0] q,
  output logic         sout
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (shift_en) begin
      q <= {q[W-2:0], sin};
    end
  end

  assign sout = q[W-1];

endmodule

// File: rtl/flc_lut_tree.sv
module flc_lut_tree
  import flc_pkg::*;
#(
  parameter int unsigned K = 4
) (
  input  logic [(1<<K)-1:0] tbl,
  input  logic [K-1:0]      sel,
  output logic              root,
  output logic [1:0]        frac
);

  localparam int unsigned TBL  = 1 << K;
  localparam int unsigned TAP0 = flc_tap_node(K, 0);
  localparam int unsigned TAP1 = flc_tap_node(K, 1);

  // Heap layout: node 1 is the root, children of n are 2n and 2n+1,
  // leaves TBL..2*TBL-1 hold the table. Depth d resolves input K-1-d.
  logic [2*TBL-1:1] t;

  genvar gi, gd;
  generate
    for (gi = 0; gi < TBL; gi++) begin : g_leaf
      assign t[TBL + gi] = tbl[gi];
    end
    for (gd = 0; gd < K; gd++) begin : g_depth
      localparam int unsigned FIRST = 1 << gd;
      for (gi = 0; gi < (1 << gd); gi++) begin : g_node
        assign t[FIRST + gi] = sel[K-1-gd] ? t[2*(FIRST + gi) + 1] : t[2*(FIRST + gi)];
      end
    end
  endgenerate

  assign root = t[1];
  assign frac = {t[TAP1], t[TAP0]};

endmodule

// File: rtl/flc_cell.sv
module flc_cell
  import flc_pkg::*;
#(
  parameter int unsigned K      = 4,
  parameter int unsigned CI_IDX = FLC_CI_INPUT
) (
  input  logic [(1<<K)-1:0] tbl,
  input  logic              ci_sel,
  input  logic [K-1:0]      li,
  input  logic              ci,
  output logic              o,
  output logic              co
);

  logic [K-1:0] lin;
  logic [1:0]   frac;

  genvar gi;
  generate
    for (gi = 0; gi < K; gi++) begin : g_in
      if (gi == CI_IDX) begin : g_sel
        assign lin[gi] = ci_sel ? ci : li[gi];
      end else begin : g_dir
        assign lin[gi] = li[gi];
      end
    end
  endgenerate

  flc_lut_tree #(.K(K)) tree_i (
    .tbl  (tbl),
    .sel  (lin),
    .root (o),
    .frac (frac)
  );

  // frac[0] propagate selects the carry leg, frac[1] generate otherwise
  assign co = frac[0] ? ci : frac[1];

endmodule

// File: rtl/flc_chain.sv
module flc_chain #(
  parameter int unsigned NCELL = 4,
  parameter int unsigned K     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_shift_en,
  input  logic               cfg_sin,
  output logic               cfg_sout,
  input  logic [NCELL*K-1:0] li,
  input  logic               ci,
  output logic [NCELL-1:0]   o,
  output logic [NCELL-1:0]   co
);

  localparam int unsigned TBL  = 1 << K;
  localparam int unsigned CFGW = TBL + 1;
  localparam int unsigned TOT  = NCELL * CFGW;

  logic [TOT-1:0] cfg_q;
  logic [NCELL:0] carry;

  flc_cfg_shift #(.W(TOT)) cfg_i (
    .clk      (clk),
    .rst      (rst),
    .shift_en (cfg_shift_en),
    .sin      (cfg_sin),
    .q        (cfg_q),
    .sout     (cfg_sout)
  );

  assign carry[0] = ci;

  genvar gk;
  generate
    for (gk = 0; gk < NCELL; gk++) begin : g_cell
      flc_cell #(.K(K)) cell_i (
        .tbl    (cfg_q[gk*CFGW +: TBL]),
        .ci_sel (cfg_q[gk*CFGW + TBL]),
        .li     (li[gk*K +: K]),
        .ci     (carry[gk]),
        .o      (o[gk]),
        .co     (carry[gk+1])
      );
    end
  endgenerate

  assign co = carry[NCELL:1];

endmodule

// File: rtl/flc_chain_chk.sv
module flc_chain_chk
  import flc_pkg::*;
#(
  parameter int unsigned NCELL = 4,
  parameter int unsigned K     = 4
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            cfg_shift_en,
  input logic                            cfg_sin,
  input logic                            cfg_sout,
  input logic [NCELL*K-1:0]              li,
  input logic                            ci,
  input logic [NCELL-1:0]                o,
  input logic [NCELL-1:0]                co,
  input logic [NCELL*((1<<K)+1)-1:0]     cfg_q
);

  localparam int unsigned TBL  = 1 << K;
  localparam int unsigned CFGW = TBL + 1;
  localparam int unsigned TOT  = NCELL * CFGW;
  localparam int unsigned PLO  = flc_tap_leaf(K, 0);
  localparam int unsigned GLO  = flc_tap_leaf(K, 1);

  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  // R1: configuration and outputs cleared on leaving reset
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (o == '0 && co == '0 && cfg_sout == 1'b0));

  // R7: a shift moves the register by one place and takes in the serial bit
  a_r7_shift_moves: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && $past(cfg_shift_en)) |->
      (cfg_q[0] == $past(cfg_sin) && cfg_sout == $past(cfg_q[TOT-2])));

  // R8: idle configuration with stable inputs keeps outputs stable
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && !$past(cfg_shift_en) && $stable(li) && $stable(ci)) |->
      ($stable(o) && $stable(co)));

  // R9: serial output holds while idle
  a_r9_sout_hold: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(rst) && !$past(cfg_shift_en)) |-> $stable(cfg_sout));

  genvar gk;
  generate
    for (gk = 0; gk < NCELL; gk++) begin : g_cell_chk
      logic cin_k;
      if (gk == 0) begin : g_first
        assign cin_k = ci;
      end else begin : g_rest
        assign cin_k = co[gk-1];
      end

      // R5: all-ones propagate slice passes the carry input through
      a_r5_propagate_pass: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[gk*CFGW + PLO +: 4] == 4'hF) |-> (co[gk] == cin_k));

      // R5: zero propagate and zero generate slices kill the carry
      a_r5_kill: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[gk*CFGW + PLO +: 4] == 4'h0 && cfg_q[gk*CFGW + GLO +: 4] == 4'h0) |->
          (co[gk] == 1'b0));

      // R2: an all-ones table drives the main output high
      a_r2_const_one: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[gk*CFGW +: TBL] == {TBL{1'b1}}) |-> (o[gk] == 1'b1));
    end
  endgenerate

endmodule

bind flc_chain flc_chain_chk #(.NCELL(NCELL), .K(K)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .cfg_shift_en (cfg_shift_en),
  .cfg_sin      (cfg_sin),
  .cfg_sout     (cfg_sout),
  .li           (li),
  .ci           (ci),
  .o            (o),
  .co           (co),
  .cfg_q        (cfg_q)
);

// File: tb/flc_chain_tb.sv
`timescale 1ns/1ps
module flc_chain_tb_top;

  localparam int N    = 4;
  localparam int K    = 4;
  localparam int CFGW = 17;
  localparam int TOT  = N * CFGW;

  typedef struct {
    logic [N-1:0] o;
    logic [N-1:0] co;
    logic         sout;
    string        tag;
  } exp_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           shift_en = 1'b0;
  logic           sin = 1'b0;
  logic           sout;
  logic [N*K-1:0] li = '0;
  logic           ci = 1'b0;
  logic [N-1:0]   o;
  logic [N-1:0]   co;

  logic [TOT-1:0] sh = '0;
  exp_t           q[$];
  int             checks = 0;
  int             failures = 0;
  logic           done = 1'b0;

  always #5 clk = ~clk;

  flc_chain #(.NCELL(N), .K(K)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .cfg_shift_en (shift_en),
    .cfg_sin      (sin),
    .cfg_sout     (sout),
    .li           (li),
    .ci           (ci),
    .o            (o),
    .co           (co)
  );

  // Reference model built from the requirements
  task automatic model(input logic [N*K-1:0] l, input logic c, output exp_t e);
    logic cr;
    cr = c;
    for (int k = 0; k < N; k++) begin
      logic [15:0] tbl;
      logic        sel, in2, p, g;
      logic [3:0]  lk;
      tbl = sh[k*CFGW +: 16];
      sel = sh[k*CFGW + 16];
      lk  = l[k*K +: K];
      in2 = sel ? cr : lk[2];                              // R3
      e.o[k] = tbl[{lk[3], in2, lk[1], lk[0]}];            // R2
      p = tbl[8 + {2'b00, lk[1], lk[0]}];                  // R4
      g = tbl[12 + {2'b00, lk[1], lk[0]}];
      cr = p ? cr : g;                                     // R5 R6
      e.co[k] = cr;
    end
    e.sout = sh[TOT-1];                                    // R9
  endtask

  // Driver: apply one input vector and queue the expected result
  task automatic apply(input logic [N*K-1:0] l, input logic c, input logic s, input string tag);
    exp_t e;
    @(negedge clk);
    shift_en = 1'b0;
    li  = l;
    ci  = c;
    sin = s;
    model(l, c, e);
    e.tag = tag;
    q.push_back(e);
  endtask

  // R7: serial load, highest bit first
  task automatic load(input logic [TOT-1:0] v);
    for (int i = TOT - 1; i >= 0; i--) begin
      @(negedge clk);
      shift_en = 1'b1;
      sin = v[i];
      sh = {sh[TOT-2:0], v[i]};
    end
    @(negedge clk);
    shift_en = 1'b0;
  endtask

  function automatic logic [CFGW-1:0] cc(input logic sel, input logic [15:0] tbl);
    return {sel, tbl};
  endfunction

  // Monitor: pop and compare one item per cycle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (o !== e.o || co !== e.co || sout !== e.sout) begin
          failures++;
          $display("FAIL %s: o=%b co=%b sout=%b expected o=%b co=%b sout=%b",
                   e.tag, o, co, sout, e.o, e.co, e.sout);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: cleared state
    apply(16'hBEEF, 1'b1, 1'b0, "R1 reset state");
    apply(16'hFFFF, 1'b0, 1'b1, "R1 reset state");

    // R2 R4 R5 R6 R7: distinct tables, LUT input 2 from general input
    load({cc(1'b0, 16'h6996), cc(1'b0, 16'hFFFF), cc(1'b0, 16'h1234), cc(1'b0, 16'h8E71)});
    for (int p = 0; p < 16; p++) begin
      logic [3:0] a, b, c2, d;
      a = p[3:0]; b = a ^ 4'h5; c2 = ~a; d = a + 4'h3;
      apply({d, c2, b, a}, 1'b0, 1'b0, "R2 R4 table sweep ci=0");
      apply({a, a, a, a}, 1'b1, 1'b0, "R2 R7 table sweep ci=1");
    end

    // R3: LUT input 2 from carry; table F0F0 makes O follow input 2
    load({cc(1'b1, 16'hF0F0), cc(1'b0, 16'hF0F0), cc(1'b1, 16'h5AF0), cc(1'b1, 16'hF0F0)});
    for (int p = 0; p < 32; p++) begin
      logic [3:0] a;
      a = p[3:0];
      apply({a, ~a, a ^ 4'h4, a}, p[4], 1'b0, "R3 input 2 source select");
    end

    // R5 R6: generate, kill, propagate, propagate
    load({cc(1'b0, 16'h0F5A), cc(1'b1, 16'h0F3C), cc(1'b0, 16'h00C3), cc(1'b1, 16'hF096)});
    for (int p = 0; p < 32; p++) begin
      logic [3:0] a;
      a = p[3:0];
      apply({a, a ^ 4'hA, ~a, a}, p[4], 1'b0, "R5 R6 propagate/generate/kill chain");
    end

    // R5 R6: 4-bit ripple adder, sum on O, carry on CO
    load({cc(1'b1, 16'h8696), cc(1'b1, 16'h8696), cc(1'b1, 16'h8696), cc(1'b1, 16'h8696)});
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        for (int c = 0; c < 2; c++) begin
          logic [N*K-1:0] l;
          for (int k = 0; k < N; k++) begin
            l[k*K +: K] = {1'b0, 1'b0, b[k], a[k]};
          end
          apply(l, c[0], 1'b0, "R5 R6 adder chain");
        end
      end
    end

    // R8: serial input toggling with shift idle has no effect
    for (int i = 0; i < 8; i++) begin
      apply(16'h3535, 1'b1, i[0], "R8 idle shift ignores serial input");
    end

    // R9: top bit now 0 after a reload with cell 3 selector clear
    load({cc(1'b0, 16'h8696), cc(1'b1, 16'h8696), cc(1'b1, 16'h8696), cc(1'b1, 16'h8696)});
    apply(16'h2121, 1'b1, 1'b1, "R9 serial output top bit");

    // R1: reset after configuration clears it again
    @(negedge clk);
    rst = 1'b1;
    sh = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    apply(16'hFFFF, 1'b1, 1'b0, "R1 reset after load");

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule